// File: doc/BRIEF.md
# Four-State Bidirectional Ring Sequencer

This block is a clocked Moore machine that walks around a ring of four states. A forward request advances it by one position, a backward request retreats it by one, and with neither request present it stays where it is. Two outputs, `x_o` and `y_o`, depend only on the present state. The two-bit state code is also brought out so that a controller can observe the position directly.

Two elaboration parameters select variants. `OUT_REG` chooses between a combinational decode of the outputs and a registered decode that lags by one clock. `SYNC_START` chooses how the machine is sent back to its starting state. With `SYNC_START=0` an active-low clear input does it at once, without a clock. With `SYNC_START=1` a start input does it on the next clock edge, and the clear input is ignored. The block also records, in a flag that only the main reset clears, any clock edge at which both requests were present.

The main reset `rst_n` takes effect asynchronously. Its release passes through a synchronizer of `SYNC_STAGES` flops, and the clear input is released through the same kind of chain.

Top module: `ring_seq_top`

## Requirements
- R1: The state code `state_o` is two bits with S0=00, S1=01, S2=10, S3=11. While `rst_n` is low the machine is in S0, the outputs are x=1, y=0 and `conflict_o` is 0.
- R2: At a clock edge with `up_req`=1, the state advances S0→S1→S2→S3→S0.
- R3: At a clock edge with `down_req`=1 and `up_req`=0, the state retreats S0→S3→S2→S1→S0.
- R4: At a clock edge with neither request present, the state is unchanged.
- R5: When both requests are 1, the forward move wins. `conflict_o` is set at the first edge with both requests high (once the main reset has been released) and stays 1 until `rst_n` goes low. The clear and start inputs do not affect it.
- R6: With `OUT_REG=0` the outputs follow the present state combinationally: S0 gives x=1,y=0; S1 gives 0,0; S2 gives 1,1; S3 gives 0,0.
- R7: With `OUT_REG=1` the outputs show the R6 pattern of the state that was held before the most recent clock edge, so they lag the combinational option by exactly one cycle. They read x=1,y=0 while the machine is held in reset.
- R8: With `SYNC_START=0`, `clr_n`=0 puts the machine in S0 at once, without waiting for a clock. After `clr_n` returns high, the state stays in S0 for 2 more rising edges, and the `start` input has no effect in this mode.
- R9: With `SYNC_START=1`, `start`=1 at a clock edge forces S0 and overrides both requests, while `clr_n` has no effect.
- R10: After `rst_n` is released, the first 2 rising edges leave the state in S0. The first move happens at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Main reset, active low, asynchronous assert and synchronized release |
| clr_n | input | 1 | Asynchronous clear to S0, active low (used when SYNC_START=0) |
| start | input | 1 | Synchronous return to S0 (used when SYNC_START=1) |
| up_req | input | 1 | Forward step request |
| down_req | input | 1 | Backward step request |
| state_o | output | 2 | Present state code |
| x_o | output | 1 | First decoded output |
| y_o | output | 1 | Second decoded output |
| conflict_o | output | 1 | Sticky flag: both requests were seen at one edge |

## Verification
The assertions assume that the request, start and clear inputs change only away from the rising clock edge. They also assume that a clear pulse lasts across at least one rising edge, so that an asynchronous clear always disables the stepping properties before their consequent is sampled. The stimulus drives every input on the falling edge and holds each clear or reset level for whole cycles. The stimulus drives both requests together only in a dedicated phase, so that the priority and sticky-flag checks can be told apart from ordinary stepping.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_ZERO  = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b10,
    ST_THREE = 2'b11
  } ring_state_e;

  typedef struct packed {
    logic x;
    logic y;
  } ring_out_t;

  localparam ring_out_t HOME_PATTERN = '{x: 1'b1, y: 1'b0};

endpackage

// File: rtl/rs_reset_sync.sv
module rs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= (chain_q << 1) | STAGES'(1);
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rs_next_state.sv
module rs_next_state
  import ring_seq_pkg::*;
(
  input  ring_state_e cur,
  input  logic        fwd,
  input  logic        back,
  input  logic        restart,
  output ring_state_e nxt,
  output logic        step_en,
  output logic        clash
);

  logic [STATE_W-1:0] inc_code;
  logic [STATE_W-1:0] dec_code;

  assign inc_code = cur + STATE_W'(1);
  assign dec_code = cur - STATE_W'(1);

  always_comb begin
    nxt = cur;
    if (restart) begin
      nxt = ST_ZERO;
    end else if (fwd) begin
      nxt = ring_state_e'(inc_code);
    end else if (back) begin
      nxt = ring_state_e'(dec_code);
    end
  end

  assign step_en = restart | fwd | back;
  assign clash   = fwd & back;

endmodule

// File: rtl/rs_decode.sv
module rs_decode
  import ring_seq_pkg::*;
(
  input  ring_state_e state,
  output ring_out_t   pattern
);

  always_comb begin
    unique case (state)
      ST_ZERO:  pattern = HOME_PATTERN;
      ST_ONE:   pattern = '{x: 1'b0, y: 1'b0};
      ST_TWO:   pattern = '{x: 1'b1, y: 1'b1};
      ST_THREE: pattern = '{x: 1'b0, y: 1'b0};
      default:  pattern = HOME_PATTERN;
    endcase
  end

endmodule

// File: rtl/ring_seq_top.sv
module ring_seq_top
  import ring_seq_pkg::*;
#(
  parameter bit OUT_REG     = 1'b0,
  parameter bit SYNC_START  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               start,
  input  logic               up_req,
  input  logic               down_req,
  output logic [STATE_W-1:0] state_o,
  output logic               x_o,
  output logic               y_o,
  output logic               conflict_o
);

  logic        st_raw_n;
  logic        st_srst_n;
  logic        main_srst_n;
  logic        restart;
  ring_state_e state_q;
  ring_state_e state_d;
  logic        step_en;
  logic        clash;
  logic        conflict_q;
  ring_out_t   pattern;

  assign st_raw_n = rst_n & (SYNC_START | clr_n);
  assign restart  = SYNC_START & start;

  rs_reset_sync #(.STAGES(SYNC_STAGES)) u_st_sync (
    .clk    (clk),
    .arst_n (st_raw_n),
    .srst_n (st_srst_n)
  );

  rs_reset_sync #(.STAGES(SYNC_STAGES)) u_main_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (main_srst_n)
  );

  rs_next_state u_next (
    .cur     (state_q),
    .fwd     (up_req),
    .back    (down_req),
    .restart (restart),
    .nxt     (state_d),
    .step_en (step_en),
    .clash   (clash)
  );

  always_ff @(posedge clk or negedge st_srst_n) begin
    if (!st_srst_n) begin
      state_q <= ST_ZERO;
    end else if (step_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge main_srst_n) begin
    if (!main_srst_n) begin
      conflict_q <= 1'b0;
    end else if (clash) begin
      conflict_q <= 1'b1;
    end
  end

  rs_decode u_decode (
    .state   (state_q),
    .pattern (pattern)
  );

  generate
    if (OUT_REG) begin : g_out_reg
      ring_out_t out_q;
      always_ff @(posedge clk or negedge st_srst_n) begin
        if (!st_srst_n) begin
          out_q <= HOME_PATTERN;
        end else begin
          out_q <= pattern;
        end
      end
      assign x_o = out_q.x;
      assign y_o = out_q.y;
    end else begin : g_out_comb
      assign x_o = pattern.x;
      assign y_o = pattern.y;
    end
  endgenerate

  assign state_o    = state_q;
  assign conflict_o = conflict_q;

endmodule

// File: rtl/ring_seq_chk.sv
module ring_seq_chk #(
  parameter bit OUT_REG    = 1'b0,
  parameter bit SYNC_START = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_n,
  input logic       restart,
  input logic       fwd,
  input logic       back,
  input logic       st_srst_n,
  input logic       main_srst_n,
  input logic [1:0] state,
  input logic       x,
  input logic       y,
  input logic       conflict
);

  assert_fwd_step_R2: assert property (@(posedge clk) disable iff (!st_srst_n)
    (fwd && !restart) |=> (state == $past(state) + 2'd1));

  assert_back_step_R3: assert property (@(posedge clk) disable iff (!st_srst_n)
    (back && !fwd && !restart) |=> (state == $past(state) - 2'd1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!st_srst_n)
    (!fwd && !back && !restart) |=> $stable(state));

  assert_conflict_sticky_R5: assert property (@(posedge clk) disable iff (!main_srst_n)
    conflict |=> conflict);

  assert_conflict_cause_R5: assert property (@(posedge clk) disable iff (!main_srst_n)
    $rose(conflict) |-> $past(fwd && back));

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> (state == 2'b00 && !conflict));

  generate
    if (OUT_REG) begin : g_reg_chk
      assert_out_lag_R7: assert property (@(posedge clk) disable iff (!st_srst_n)
        (x == ($past(state) == 2'b00 || $past(state) == 2'b10)) &&
        (y == ($past(state) == 2'b10)));
    end else begin : g_comb_chk
      assert_out_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b01 || state == 2'b11) |-> (!x && !y));
      assert_out_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b10) |-> (x && y));
    end
    if (SYNC_START) begin : g_sync_chk
      assert_start_home_R9: assert property (@(posedge clk) disable iff (!st_srst_n)
        restart |=> (state == 2'b00));
    end else begin : g_async_chk
      assert_clear_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (state == 2'b00));
    end
  endgenerate

endmodule

bind ring_seq_top ring_seq_chk #(.OUT_REG(OUT_REG), .SYNC_START(SYNC_START)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_n       (clr_n),
  .restart     (restart),
  .fwd         (up_req),
  .back        (down_req),
  .st_srst_n   (st_srst_n),
  .main_srst_n (main_srst_n),
  .state       (state_q),
  .x           (x_o),
  .y           (y_o),
  .conflict    (conflict_o)
);

// File: tb/test_ring_seq_top.sv
module test_ring_seq_top;

  logic clk = 1'b0;
  logic rst_n, clr_n, start, up_req, down_req;
  logic [1:0] st_a, st_b;
  logic xa, ya, ca, xb, yb, cb;

  int n_chk = 0;
  int n_err = 0;
  string last_tag = "R1";

  // model variables
  int s_a, s_b, rel_a, rel_b, rel_m, conf, ob_x, ob_y;

  always #2 clk = ~clk;

  ring_seq_top #(.OUT_REG(1'b0), .SYNC_START(1'b0)) i_ring_seq_top (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .start(start),
    .up_req(up_req), .down_req(down_req),
    .state_o(st_a), .x_o(xa), .y_o(ya), .conflict_o(ca)
  );

  ring_seq_top #(.OUT_REG(1'b1), .SYNC_START(1'b1)) i_ring_seq_top_b (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .start(start),
    .up_req(up_req), .down_req(down_req),
    .state_o(st_b), .x_o(xb), .y_o(yb), .conflict_o(cb)
  );

  function automatic int pat_x(int s);
    return (s == 0 || s == 2) ? 1 : 0;
  endfunction

  function automatic int pat_y(int s);
    return (s == 2) ? 1 : 0;
  endfunction

  function automatic int step_of(int s, bit u, bit d);
    if (u) return (s + 1) % 4;
    if (d) return (s + 3) % 4;
    return s;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "async-mode state", int'(st_a), s_a);
    chk("R6", "comb x", int'(xa), pat_x(s_a));
    chk("R6", "comb y", int'(ya), pat_y(s_a));
    chk("R5", "conflict A", int'(ca), conf);
    chk(tag, "sync-mode state", int'(st_b), s_b);
    chk("R7", "registered x", int'(xb), ob_x);
    chk("R7", "registered y", int'(yb), ob_y);
    chk("R5", "conflict B", int'(cb), conf);
  endtask

  task automatic apply_async();
    if (!rst_n) begin
      rel_m = 0; conf = 0;
      rel_b = 0; s_b = 0; ob_x = 1; ob_y = 0;
    end
    if (!(rst_n && clr_n)) begin
      rel_a = 0; s_a = 0;
    end
  endtask

  task automatic edge_model();
    if (rst_n) begin
      if (rel_m < 2) rel_m++;
      else if (up_req && down_req) conf = 1;
    end
    if (rst_n && clr_n) begin
      if (rel_a < 2) rel_a++;
      else s_a = step_of(s_a, up_req, down_req);
    end
    if (rst_n) begin
      if (rel_b < 2) rel_b++;
      else begin
        ob_x = pat_x(s_b);
        ob_y = pat_y(s_b);
        s_b = start ? 0 : step_of(s_b, up_req, down_req);
      end
    end
  endtask

  task automatic cyc(bit u, bit d, bit st, bit cl, bit rs, string tag);
    @(negedge clk);
    compare(last_tag);
    up_req = u; down_req = d; start = st; clr_n = cl; rst_n = rs;
    apply_async();
    #1;
    compare(tag);
    @(posedge clk);
    edge_model();
    last_tag = tag;
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; start = 1'b0; up_req = 1'b0; down_req = 1'b0;
    apply_async();
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    // R10: requests during release are ignored for two edges
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
    // R2: forward with wrap
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
    // R4: hold
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
    // R3: backward with wrap
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    // R6: mixed pattern without overlap
    for (int i = 0; i < 24; i++)
      cyc(i % 3 == 0, (i % 4 == 1) && (i % 3 != 0), 1'b0, 1'b1, 1'b1, "R6");
    // R5: both requests, forward wins, flag sticks
    for (int i = 0; i < 2; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
    // R8: async clear (sync-mode copy ignores it, R9)
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    // R9: sync start (async-mode copy ignores it, R8)
    for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    // R1 / R5: main reset clears the flag
    for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
    @(negedge clk);
    compare(last_tag);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule